// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds a bank of byte-wide configuration registers. Each register has two stages: a staging byte that the host or the storage loader writes, and an active byte that drives the controlled functions. All active bytes appear together on one wide output vector. After reset, a loader copies the whole configuration image from nonvolatile storage into the staging bytes, one byte per request. Once the last byte has landed, it moves every staging byte into its active byte in a single cycle.

At runtime the host reaches the bank through a simple byte port. A control register selects how host writes take effect. In transparent mode a write reaches both stages at once. In staged mode a write reaches only the staging byte, and a one-shot commit later moves all staging bytes together. The same control register gates erase requests to the storage. A second control register restarts the storage copy without a power cycle. While any copy is running the block reports busy, and it refuses host accesses by withholding the acknowledge.

Top module: `cfg_dbuf_bank`

## Requirements
- R1: While reset is high, and on the first cycle after it, `busy` is 1 and every byte of `cfg_active` is zero.
- R2: Each copy issues exactly NUM_REGS storage reads. Each read is a one-cycle `nv_req` pulse with at most one read outstanding. The addresses are {0xF8, i} for i = 0 up to NUM_REGS-1, in rising order.
- R3: During a copy `cfg_active` does not change. The cycle after the last byte arrives, every active byte equals the byte read for its index, and `busy` falls in that same cycle.
- R4: While `busy` is 1, a host read or write gets no `host_ack` and changes neither stage.
- R5: With bit 0 of the control register at address 0x90 set to 1, an accepted host data write shows on the active byte one cycle after the write.
- R6: With bit 0 of 0x90 at 0, a host data write changes only the staging byte, which reads back through the host port. The active byte keeps its value.
- R7: Writing a value with bit 1 set to 0x90 moves every staging byte into its active byte one cycle later. Bit 1 always reads back as 0.
- R8: A `host_erase` pulse yields a one-cycle `erase_go` on the next cycle only when bit 2 of 0x90 is 1 and the block is not busy. Otherwise `erase_go` stays 0.
- R9: Writing a value with bit 0 set to address 0xD8 starts a new copy from storage. Active bytes keep their old values until that copy's final commit. 0xD8 reads back as 0.
- R10: Host addresses at NUM_REGS or above (default 0xE0 to 0xFF) get no acknowledge. Address NUM_REGS-1 is accepted.
- R11: An accepted access gets `host_ack` high for one cycle on the cycle after the request. For a read, `host_rdata` then holds the staging byte. Reading 0x90 returns {bit2, 0, bit0} in the low three bits, with the other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write request |
| host_re | input | 1 | Host read request |
| host_addr | input | AW | Host register address |
| host_wdata | input | DW | Host write data |
| host_erase | input | 1 | Host request to erase a storage page |
| host_ack | output | 1 | Access accepted, one cycle after the request |
| host_rdata | output | DW | Read data, valid with `host_ack` |
| busy | output | 1 | A storage copy is running |
| erase_go | output | 1 | Erase request forwarded to storage |
| nv_req | output | 1 | Storage read request pulse |
| nv_addr | output | NV_AW | Storage read address |
| nv_rdata | input | DW | Storage read data |
| nv_rvalid | input | 1 | Storage read data valid |
| cfg_active | output | NUM_REGS*DW | All active bytes, index i at bits [i*DW +: DW] |

## Verification
The hardest state to reach is a reload that overlaps different staged and active contents. The bench must first leave committed values, transparently written values and untouched power-up values in the bank. It must then change the storage model's contents and trigger the reload. Partway through that reload it checks that all three kinds of active value are still intact, and after the commit it checks that every byte matches the new image. The staged case works the same way: readback shows the staging byte while the active output still shows the old value, until the commit pulse arrives.

// File: rtl/cfg_dbuf_pkg.sv
package cfg_dbuf_pkg;
  typedef enum logic [1:0] {
    LD_IDLE,
    LD_REQ,
    LD_WAIT,
    LD_COMMIT
  } ld_state_t;

  localparam int UPD_TRANSP_BIT = 0;
  localparam int UPD_COMMIT_BIT = 1;
  localparam int UPD_ERASE_BIT  = 2;
  localparam int RELOAD_BIT     = 0;
endpackage

// File: rtl/cfg_dbl_reg.sv
module cfg_dbl_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stg_we,
  input  logic [DW-1:0] stg_d,
  input  logic          act_we,
  input  logic [DW-1:0] act_d,
  input  logic          commit,
  output logic [DW-1:0] stg_q,
  output logic [DW-1:0] act_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
      act_q <= '0;
    end else begin
      if (stg_we) stg_q <= stg_d;
      // a global commit outranks a direct transparent write
      if (commit)      act_q <= stg_q;
      else if (act_we) act_q <= act_d;
    end
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_dbuf_pkg::*;
#(
  parameter int           NUM_REGS = 224,
  parameter int           DW       = 8,
  parameter int           NV_AW    = 16,
  parameter logic [7:0]   NV_HI    = 8'hF8,
  parameter int           IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             nv_req,
  output logic [NV_AW-1:0] nv_addr,
  input  logic [DW-1:0]    nv_rdata,
  input  logic             nv_rvalid,
  output logic             ld_we,
  output logic [IDX_W-1:0] ld_idx,
  output logic [DW-1:0]    ld_data,
  output logic             commit,
  output logic             busy
);
  localparam int               LO_W = NV_AW - 8;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

  ld_state_t        state;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LD_REQ;
      idx     <= '0;
      nv_req  <= 1'b0;
      nv_addr <= '0;
      busy    <= 1'b1;
    end else begin
      case (state)
        LD_IDLE: begin
          if (start) begin
            state <= LD_REQ;
            idx   <= '0;
            busy  <= 1'b1;
          end
        end
        LD_REQ: begin
          nv_req  <= 1'b1;
          nv_addr <= {NV_HI, LO_W'(idx)};
          state   <= LD_WAIT;
        end
        LD_WAIT: begin
          nv_req <= 1'b0;
          if (nv_rvalid) begin
            if (idx == LAST) begin
              state <= LD_COMMIT;
            end else begin
              idx   <= idx + 1'b1;
              state <= LD_REQ;
            end
          end
        end
        LD_COMMIT: begin
          state <= LD_IDLE;
          busy  <= 1'b0;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  assign ld_we   = (state == LD_WAIT) && nv_rvalid;
  assign ld_idx  = idx;
  assign ld_data = nv_rdata;
  assign commit  = (state == LD_COMMIT);
endmodule

// File: rtl/cfg_host_port.sv
module cfg_host_port
  import cfg_dbuf_pkg::*;
#(
  parameter int          NUM_REGS    = 224,
  parameter int          DW          = 8,
  parameter int          AW          = 8,
  parameter logic [7:0]  UPD_ADDR    = 8'h90,
  parameter logic [7:0]  RELOAD_ADDR = 8'hD8,
  parameter int          IDX_W       = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   busy,
  input  logic                   host_we,
  input  logic                   host_re,
  input  logic [AW-1:0]          host_addr,
  input  logic [DW-1:0]          host_wdata,
  input  logic                   host_erase,
  input  logic [NUM_REGS*DW-1:0] stg_flat,
  output logic                   host_ack,
  output logic [DW-1:0]          host_rdata,
  output logic                   wr_we,
  output logic [IDX_W-1:0]       wr_idx,
  output logic [DW-1:0]          wr_data,
  output logic                   transp,
  output logic                   host_commit,
  output logic                   reload,
  output logic                   erase_go
);
  logic in_range, accept, acc_wr, acc_rd, is_upd, is_rld, erase_en;

  assign in_range = (int'(host_addr) < NUM_REGS);
  assign accept   = (host_we || host_re) && !busy && in_range;
  assign acc_wr   = accept && host_we;
  assign acc_rd   = accept && host_re;
  assign is_upd   = (host_addr == AW'(UPD_ADDR));
  assign is_rld   = (host_addr == AW'(RELOAD_ADDR));

  assign wr_idx  = host_addr[IDX_W-1:0];
  assign wr_data = host_wdata;
  assign wr_we   = acc_wr && !is_upd && !is_rld;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ack    <= 1'b0;
      host_rdata  <= '0;
      transp      <= 1'b0;
      erase_en    <= 1'b0;
      host_commit <= 1'b0;
      reload      <= 1'b0;
      erase_go    <= 1'b0;
    end else begin
      host_ack    <= accept;
      host_commit <= acc_wr && is_upd && host_wdata[UPD_COMMIT_BIT];
      reload      <= acc_wr && is_rld && host_wdata[RELOAD_BIT];
      erase_go    <= host_erase && !busy && erase_en;
      if (acc_wr && is_upd) begin
        transp   <= host_wdata[UPD_TRANSP_BIT];
        erase_en <= host_wdata[UPD_ERASE_BIT];
      end
      if (acc_rd) begin
        if (is_upd)      host_rdata <= DW'({erase_en, 1'b0, transp});
        else if (is_rld) host_rdata <= '0;
        else             host_rdata <= stg_flat[int'(wr_idx)*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/cfg_dbuf_bank.sv
module cfg_dbuf_bank
  import cfg_dbuf_pkg::*;
#(
  parameter int         NUM_REGS    = 224,
  parameter int         DW          = 8,
  parameter int         AW          = 8,
  parameter int         NV_AW       = 16,
  parameter logic [7:0] NV_HI       = 8'hF8,
  parameter logic [7:0] UPD_ADDR    = 8'h90,
  parameter logic [7:0] RELOAD_ADDR = 8'hD8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_we,
  input  logic                   host_re,
  input  logic [AW-1:0]          host_addr,
  input  logic [DW-1:0]          host_wdata,
  input  logic                   host_erase,
  output logic                   host_ack,
  output logic [DW-1:0]          host_rdata,
  output logic                   busy,
  output logic                   erase_go,
  output logic                   nv_req,
  output logic [NV_AW-1:0]       nv_addr,
  input  logic [DW-1:0]          nv_rdata,
  input  logic                   nv_rvalid,
  output logic [NUM_REGS*DW-1:0] cfg_active
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic             ld_we, ld_commit, wr_we, transp, host_commit, reload, commit_all;
  logic [IDX_W-1:0] ld_idx, wr_idx, sel_idx;
  logic [DW-1:0]    ld_data, wr_data, sel_data;
  logic             sel_we;
  logic [NUM_REGS*DW-1:0] stg_flat;

  cfg_loader #(
    .NUM_REGS(NUM_REGS), .DW(DW), .NV_AW(NV_AW), .NV_HI(NV_HI), .IDX_W(IDX_W)
  ) u_loader (
    .clk(clk), .rst(rst), .start(reload),
    .nv_req(nv_req), .nv_addr(nv_addr), .nv_rdata(nv_rdata), .nv_rvalid(nv_rvalid),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .commit(ld_commit), .busy(busy)
  );

  cfg_host_port #(
    .NUM_REGS(NUM_REGS), .DW(DW), .AW(AW),
    .UPD_ADDR(UPD_ADDR), .RELOAD_ADDR(RELOAD_ADDR), .IDX_W(IDX_W)
  ) u_host (
    .clk(clk), .rst(rst), .busy(busy),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_erase(host_erase), .stg_flat(stg_flat),
    .host_ack(host_ack), .host_rdata(host_rdata),
    .wr_we(wr_we), .wr_idx(wr_idx), .wr_data(wr_data), .transp(transp),
    .host_commit(host_commit), .reload(reload), .erase_go(erase_go)
  );

  // loader writes only while busy, host only while idle: never both at once
  assign sel_we     = ld_we || wr_we;
  assign sel_idx    = ld_we ? ld_idx  : wr_idx;
  assign sel_data   = ld_we ? ld_data : wr_data;
  assign commit_all = ld_commit || host_commit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = (sel_idx == IDX_W'(i));
    cfg_dbl_reg #(.DW(DW)) u_reg (
      .clk(clk), .rst(rst),
      .stg_we(sel_we && hit), .stg_d(sel_data),
      .act_we(wr_we && transp && hit), .act_d(wr_data),
      .commit(commit_all),
      .stg_q(stg_flat[i*DW +: DW]),
      .act_q(cfg_active[i*DW +: DW])
    );
  end
endmodule

// File: rtl/cfg_dbuf_bank_chk.sv
module cfg_dbuf_bank_chk #(
  parameter int NUM_REGS = 224,
  parameter int DW       = 8,
  parameter int AW       = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   host_we,
  input logic                   host_re,
  input logic [AW-1:0]          host_addr,
  input logic                   host_erase,
  input logic                   host_ack,
  input logic                   busy,
  input logic                   erase_go,
  input logic                   nv_req,
  input logic [NUM_REGS*DW-1:0] cfg_active
);
  AST_ACK_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> !$past(busy)); // R4

  AST_NO_ACK_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    ((host_we || host_re) && int'(host_addr) >= NUM_REGS) |=> !host_ack); // R10

  AST_ACTIVE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfg_active)); // R3

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    nv_req |=> !nv_req); // R2

  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    nv_req |-> busy); // R2

  AST_ERASE_GATED: assert property (@(posedge clk) disable iff (rst)
    erase_go |-> ($past(host_erase) && !$past(busy))); // R8
endmodule

bind cfg_dbuf_bank cfg_dbuf_bank_chk #(.NUM_REGS(NUM_REGS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
  .host_erase(host_erase), .host_ack(host_ack), .busy(busy), .erase_go(erase_go),
  .nv_req(nv_req), .cfg_active(cfg_active)
);

// File: tb/sim_cfg_dbuf_bank.sv
module sim_cfg_dbuf_bank;
  localparam int N = 224;

  logic clk = 0, rst = 1;
  logic host_we = 0, host_re = 0, host_erase = 0, nv_rvalid = 0;
  logic [7:0] host_addr = 0, host_wdata = 0, nv_rdata = 0;
  logic host_ack, busy, erase_go, nv_req;
  logic [7:0] host_rdata;
  logic [15:0] nv_addr;
  logic [N*8-1:0] cfg_active;

  always #5 clk = ~clk;

  cfg_dbuf_bank u0 (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_erase(host_erase), .host_ack(host_ack),
    .host_rdata(host_rdata), .busy(busy), .erase_go(erase_go), .nv_req(nv_req),
    .nv_addr(nv_addr), .nv_rdata(nv_rdata), .nv_rvalid(nv_rvalid), .cfg_active(cfg_active)
  );

  int checks = 0, fails = 0, gen = 0, req_cnt = 0, order_err = 0;
  bit done = 0;

  function automatic logic [7:0] pat(int i, int g);
    return 8'((i * 37 + 11 + g * 91) ^ (g * 90));
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // storage model: one cycle between request and data
  logic       d1_v = 0;
  logic [7:0] d1_a = 0;
  always @(negedge clk) begin
    nv_rvalid = d1_v;
    nv_rdata  = pat(int'(d1_a), gen);
    d1_v      = nv_req;
    if (nv_req) begin
      if (nv_addr != {8'hF8, 8'(req_cnt % N)}) order_err++;
      d1_a = nv_addr[7:0];
      req_cnt++;
    end
  end

  // scoreboard
  typedef struct { bit rd; logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always @(negedge clk) begin
    if (!rst && host_ack) begin
      if (sb.size() == 0) begin
        check(0, "R4/R10 unexpected ack", 1, 0);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (it.rd) check(host_rdata == it.exp, it.tag, host_rdata, it.exp);
      end
    end
  end

  task automatic host_access(bit we, bit re, logic [7:0] addr, logic [7:0] data,
                             bit exp_ack, logic [7:0] exp_rd, string tag);
    item_t it;
    @(negedge clk);
    host_we = we; host_re = re; host_addr = addr; host_wdata = data;
    if (exp_ack) begin
      it.rd = re; it.exp = exp_rd; it.tag = tag;
      sb.push_back(it);
    end
    @(negedge clk);
    host_we = 0; host_re = 0;
    if (!exp_ack) check(host_ack == 0, tag, 32'(host_ack), 0);
  endtask

  task automatic erase_pulse(bit exp, string tag);
    @(negedge clk); host_erase = 1;
    @(negedge clk); host_erase = 0;
    check(erase_go == exp, tag, 32'(erase_go), 32'(exp));
    @(negedge clk);
    check(erase_go == 0, tag, 32'(erase_go), 0);
  endtask

  function automatic logic [7:0] act(int i);
    return cfg_active[i*8 +: 8];
  endfunction

  task automatic check_image(int g, string tag);
    int bad = 0;
    for (int i = 0; i < N; i++) if (act(i) != pat(i, g)) bad++;
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy == 1, "R1 busy in reset", 32'(busy), 1);
    check(cfg_active == '0, "R1 active zero in reset", 32'(cfg_active != 0), 0);
    rst = 0;
    @(negedge clk);
    check(busy == 1, "R1 busy after reset", 32'(busy), 1);
    check(cfg_active == '0, "R1 active zero after reset", 32'(cfg_active != 0), 0);
    // R3 and R4 during power-up copy
    repeat (100) @(negedge clk);
    check(cfg_active == '0, "R3 active held during copy", 32'(cfg_active != 0), 0);
    host_access(1, 0, 8'h05, 8'hEE, 0, 0, "R4 write refused while busy");
    host_access(0, 1, 8'h05, 8'h00, 0, 0, "R4 read refused while busy");
    wait_idle();
    check(req_cnt == N, "R2 request count", req_cnt, N);
    check(order_err == 0, "R2 address order", order_err, 0);
    check_image(0, "R3 simultaneous commit of image");
    host_access(0, 1, 8'h05, 0, 1, pat(5, 0), "R4 busy write had no effect");
    host_access(0, 1, 8'h90, 0, 1, 8'h00, "R11 control reads zero");
    // R6 staged writes
    host_access(1, 0, 8'h10, 8'hA5, 1, 0, "R6 staged write");
    host_access(1, 0, 8'h20, 8'h3C, 1, 0, "R6 staged write");
    check(act(16) == pat(16, 0), "R6 active unchanged", act(16), pat(16, 0));
    host_access(0, 1, 8'h10, 0, 1, 8'hA5, "R6 R11 staging readback");
    // R7 commit
    host_access(1, 0, 8'h90, 8'h02, 1, 0, "R7 commit write");
    @(negedge clk);
    check(act(16) == 8'hA5, "R7 commit 0x10", act(16), 8'hA5);
    check(act(32) == 8'h3C, "R7 commit 0x20", act(32), 8'h3C);
    host_access(0, 1, 8'h90, 0, 1, 8'h00, "R7 commit bit self clears");
    // R5 transparent
    host_access(1, 0, 8'h90, 8'h01, 1, 0, "R5 set transparent");
    host_access(1, 0, 8'h30, 8'h77, 1, 0, "R5 transparent write");
    check(act(48) == 8'h77, "R5 active follows write", act(48), 8'h77);
    host_access(0, 1, 8'h90, 0, 1, 8'h01, "R11 control readback");
    // R8 erase gating
    erase_pulse(0, "R8 erase blocked");
    host_access(1, 0, 8'h90, 8'h05, 1, 0, "R8 enable erase");
    erase_pulse(1, "R8 erase forwarded");
    host_access(0, 1, 8'h90, 0, 1, 8'h05, "R11 control readback erase");
    // R10 range
    host_access(1, 0, 8'hE0, 8'h11, 0, 0, "R10 write 0xE0 refused");
    host_access(0, 1, 8'hF0, 8'h00, 0, 0, "R10 read 0xF0 refused");
    host_access(1, 0, 8'hDF, 8'h99, 1, 0, "R10 last address accepted");
    check(act(223) == 8'h99, "R10 R5 last address active", act(223), 8'h99);
    // R9 reload
    gen = 1;
    host_access(1, 0, 8'hD8, 8'h01, 1, 0, "R9 reload trigger");
    repeat (2) @(negedge clk);
    check(busy == 1, "R9 busy during reload", 32'(busy), 1);
    host_access(1, 0, 8'h40, 8'h12, 0, 0, "R4 write refused in reload");
    repeat (300) @(negedge clk);
    check(act(16) == 8'hA5, "R9 old committed kept", act(16), 8'hA5);
    check(act(48) == 8'h77, "R9 old transparent kept", act(48), 8'h77);
    check(act(64) == pat(64, 0), "R9 old image kept", act(64), pat(64, 0));
    wait_idle();
    check(req_cnt == 2 * N, "R2 reload request count", req_cnt, 2 * N);
    check(order_err == 0, "R2 reload address order", order_err, 0);
    check_image(1, "R9 R3 new image committed");
    host_access(0, 1, 8'hD8, 0, 1, 8'h00, "R9 reload reg reads zero");
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R11 all expected acks seen", sb.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule